// File: doc/BRIEF.md
# Circular Buffer Address Generator

This block computes the post-modified value of a data pointer for a DSP-style address generation unit that supports hardware circular buffers. Each data space holds one buffer description: a start address, an end address, the index of the general register that acts as the circular pointer, and an enable bit. When a post-modify is requested, the block takes the current pointer value, the register index it came from, the access size and the step direction. It returns the next pointer value one cycle later.

If the request comes through the selected register and the step crosses a buffer edge, the returned pointer is wrapped to the opposite edge. Software therefore never has to test the boundary itself. Every other request gets a plain linear update of one byte or one word.

Two independent lanes model the two data spaces. The primary lane accepts byte and word buffers. The secondary lane is word-only: byte requests on it are never wrapped. The register file, the memories and the instruction decoding sit outside this block.

Top module: `circbuf_agen`

## Requirements
- R1: After reset both response valids are 0, and both spaces have circular mode disabled until a configuration write (`*_cfg_wr` = 1) loads new values.
- R2: A request with `*_req_vld` = 1 produces `*_rsp_vld` = 1 with its result on `*_rsp_ptr` exactly one clock later. While no request is given, `*_rsp_ptr` holds its value.
- R3: The linear update is +2 / -2 for a word request (`*_req_byte` = 0) and +1 / -1 for a byte request (`*_req_byte` = 1). `*_req_dec` = 1 selects decrement. This update applies whenever circular mode is off for a request: the space is disabled, or the register index differs from the selected one.
- R4: A word increment through the selected register, from a pointer whose word address (bits 15:1) equals that of the end address, returns the start address with bit 0 cleared.
- R5: A word decrement through the selected register, from a pointer whose word address equals that of the start address, returns the end address with bit 0 cleared.
- R6: In a byte-mode circular buffer, the wrap test compares word addresses and ignores bit 0. A byte increment at an odd address in the end word returns the start address with bit 0 = 0. At the even address of that word it steps linearly by +1.
- R7: A byte decrement at the even address in the start word returns the end address with bit 0 = 1. At the odd address of that word it steps linearly by -1.
- R8: Register index 15 never enables circular mode, even when it is the configured selection and the space is enabled.
- R9: On the secondary space, a byte request is never wrapped; it always gets the linear byte update.
- R10: The two spaces keep separate configurations. Requests issued in the same cycle on both spaces are each handled against their own buffer.
- R11: A circular request whose pointer lies inside the buffer and does not cross an edge returns the linear update. The result therefore stays inside the buffer.
- R12: Bit 0 of the configured start and end addresses has no effect on any result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_cfg_wr | input | 1 | Load the primary-space configuration |
| p_cfg_en | input | 1 | Primary circular mode enable |
| p_cfg_sel | input | 4 | Primary selected pointer register index |
| p_cfg_start | input | 16 | Primary buffer start address |
| p_cfg_end | input | 16 | Primary buffer end address |
| p_req_vld | input | 1 | Primary post-modify request |
| p_req_reg | input | 4 | Register index of the primary request |
| p_req_ptr | input | 16 | Current pointer value, primary |
| p_req_byte | input | 1 | 1 = byte access, 0 = word access (primary) |
| p_req_dec | input | 1 | 1 = decrement, 0 = increment (primary) |
| p_rsp_vld | output | 1 | Primary result valid |
| p_rsp_ptr | output | 16 | Primary next pointer value |
| s_cfg_wr | input | 1 | Load the secondary-space configuration |
| s_cfg_en | input | 1 | Secondary circular mode enable |
| s_cfg_sel | input | 4 | Secondary selected pointer register index |
| s_cfg_start | input | 16 | Secondary buffer start address |
| s_cfg_end | input | 16 | Secondary buffer end address |
| s_req_vld | input | 1 | Secondary post-modify request |
| s_req_reg | input | 4 | Register index of the secondary request |
| s_req_ptr | input | 16 | Current pointer value, secondary |
| s_req_byte | input | 1 | 1 = byte access, 0 = word access (secondary) |
| s_req_dec | input | 1 | 1 = decrement, 0 = increment (secondary) |
| s_rsp_vld | output | 1 | Secondary result valid |
| s_rsp_ptr | output | 16 | Secondary next pointer value |

## Verification
The primary space is swept over every byte address from a few words below an eight-word buffer to a few words above it, in both directions, both sizes, and both through the selected register and through another register. This separates the wrap cases, including the odd/even split inside the edge words, from linear stepping inside and outside the buffer. The secondary space is swept the same way. Its byte requests pin down that byte wrapping is refused there, while its word requests confirm that wrapping still works. Separate patterns cover register 15 as the selection, a disabled space, start and end addresses with bit 0 set, and simultaneous requests on both spaces with different buffers, so that any leakage between the two configurations shows up.

// File: rtl/circbuf_pkg.sv
package circbuf_pkg;

    parameter int ADDR_W = 16;
    parameter int REG_W  = 4;

    localparam int                NUM_REGS = 1 << REG_W;
    localparam logic [REG_W-1:0]  EXCL_REG = REG_W'(NUM_REGS - 1);

    // buffer description held per data space; edges kept as word addresses
    typedef struct packed {
        logic              en;
        logic [REG_W-1:0]  sel;
        logic [ADDR_W-1:1] first_w;
        logic [ADDR_W-1:1] last_w;
    } cbuf_cfg_t;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] ptr;
    } cbuf_rsp_t;

endpackage

// File: rtl/circbuf_cfg.sv
module circbuf_cfg
    import circbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic              en_i,
    input  logic [REG_W-1:0]  sel_i,
    input  logic [ADDR_W-1:0] start_i,
    input  logic [ADDR_W-1:0] end_i,
    output cbuf_cfg_t         cfg_o
);

    cbuf_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            cfg_d.en      = en_i;
            cfg_d.sel     = sel_i;
            cfg_d.first_w = start_i[ADDR_W-1:1];
            cfg_d.last_w  = end_i[ADDR_W-1:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en      <= 1'b0;
            cfg_q.sel     <= EXCL_REG;
            cfg_q.first_w <= '0;
            cfg_q.last_w  <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

    // R1: circular mode stays off until a configuration write
    a_r1_en_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_i && !cfg_q.en) |=> !cfg_q.en);

endmodule

// File: rtl/circbuf_step.sv
module circbuf_step
    import circbuf_pkg::*;
#(
    parameter bit BYTE_OK = 1'b1
) (
    input  cbuf_cfg_t         cfg_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [ADDR_W-1:0] ptr_i,
    input  logic              byte_i,
    input  logic              dec_i,
    output logic              mod_on_o,
    output logic [ADDR_W-1:0] next_o
);

    logic              byte_allowed;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] lin;
    logic              at_last, at_first;
    logic              wrap_up, wrap_dn;

    generate
        if (BYTE_OK) begin : g_byte_space
            assign byte_allowed = 1'b1;
        end else begin : g_word_space
            assign byte_allowed = 1'b0;
        end
    endgenerate

    always_comb begin
        step     = byte_i ? ADDR_W'(1) : ADDR_W'(2);
        lin      = dec_i ? (ptr_i - step) : (ptr_i + step);
        mod_on_o = cfg_i.en
                 && (cfg_i.sel != EXCL_REG)
                 && (reg_i == cfg_i.sel)
                 && (byte_allowed || !byte_i);
        at_last  = (ptr_i[ADDR_W-1:1] == cfg_i.last_w);
        at_first = (ptr_i[ADDR_W-1:1] == cfg_i.first_w);
        // a byte step leaves the edge word only from its far byte
        wrap_up  = mod_on_o && !dec_i && at_last  && (!byte_i ||  ptr_i[0]);
        wrap_dn  = mod_on_o &&  dec_i && at_first && (!byte_i || !ptr_i[0]);
        if (wrap_up)
            next_o = {cfg_i.first_w, 1'b0};
        else if (wrap_dn)
            next_o = {cfg_i.last_w, byte_i};
        else
            next_o = lin;
    end

endmodule

// File: rtl/circbuf_lane.sv
module circbuf_lane
    import circbuf_pkg::*;
#(
    parameter bit BYTE_OK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_en,
    input  logic [REG_W-1:0]  cfg_sel,
    input  logic [ADDR_W-1:0] cfg_start,
    input  logic [ADDR_W-1:0] cfg_end,
    input  logic              req_vld,
    input  logic [REG_W-1:0]  req_reg,
    input  logic [ADDR_W-1:0] req_ptr,
    input  logic              req_byte,
    input  logic              req_dec,
    output logic              rsp_vld,
    output logic [ADDR_W-1:0] rsp_ptr
);

    cbuf_cfg_t         cfg_q;
    logic              mod_on;
    logic [ADDR_W-1:0] next_ptr;
    cbuf_rsp_t         rsp_d, rsp_q;

    circbuf_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr),
        .en_i    (cfg_en),
        .sel_i   (cfg_sel),
        .start_i (cfg_start),
        .end_i   (cfg_end),
        .cfg_o   (cfg_q)
    );

    circbuf_step #(.BYTE_OK(BYTE_OK)) u_step (
        .cfg_i    (cfg_q),
        .reg_i    (req_reg),
        .ptr_i    (req_ptr),
        .byte_i   (req_byte),
        .dec_i    (req_dec),
        .mod_on_o (mod_on),
        .next_o   (next_ptr)
    );

    always_comb begin
        rsp_d.vld = req_vld;
        rsp_d.ptr = req_vld ? next_ptr : rsp_q.ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_q.vld <= 1'b0;
            rsp_q.ptr <= '0;
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_vld = rsp_q.vld;
    assign rsp_ptr = rsp_q.ptr;

    // checker-side linear reference, used only by the properties below
    logic [ADDR_W-1:0] chk_lin;
    assign chk_lin = req_byte ? (req_dec ? req_ptr - ADDR_W'(1) : req_ptr + ADDR_W'(1))
                              : (req_dec ? req_ptr - ADDR_W'(2) : req_ptr + ADDR_W'(2));

    a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> (!rsp_vld && $stable(rsp_ptr)));

    a_r3_disabled_linear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !cfg_q.en) |=> (rsp_ptr == $past(chk_lin)));

    a_r8_reg15_linear: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_reg == EXCL_REG) |=> (rsp_ptr == $past(chk_lin)));

    a_r4_word_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && mod_on && !req_byte && !req_dec
         && req_ptr[ADDR_W-1:1] == cfg_q.last_w)
        |=> (rsp_ptr == {$past(cfg_q.first_w), 1'b0}));

    a_r11_stays_inside: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && mod_on && cfg_q.first_w <= cfg_q.last_w
         && req_ptr[ADDR_W-1:1] >= cfg_q.first_w
         && req_ptr[ADDR_W-1:1] <= cfg_q.last_w)
        |=> (rsp_ptr[ADDR_W-1:1] >= $past(cfg_q.first_w)
             && rsp_ptr[ADDR_W-1:1] <= $past(cfg_q.last_w)));

    generate
        if (!BYTE_OK) begin : g_word_only_chk
            a_r9_no_byte_wrap: assert property (@(posedge clk) disable iff (!rst_n)
                (req_vld && req_byte) |=> (rsp_ptr == $past(chk_lin)));
        end
    endgenerate

endmodule

// File: rtl/circbuf_agen.sv
module circbuf_agen
    import circbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p_cfg_wr,
    input  logic              p_cfg_en,
    input  logic [3:0]        p_cfg_sel,
    input  logic [15:0]       p_cfg_start,
    input  logic [15:0]       p_cfg_end,
    input  logic              p_req_vld,
    input  logic [3:0]        p_req_reg,
    input  logic [15:0]       p_req_ptr,
    input  logic              p_req_byte,
    input  logic              p_req_dec,
    output logic              p_rsp_vld,
    output logic [15:0]       p_rsp_ptr,
    input  logic              s_cfg_wr,
    input  logic              s_cfg_en,
    input  logic [3:0]        s_cfg_sel,
    input  logic [15:0]       s_cfg_start,
    input  logic [15:0]       s_cfg_end,
    input  logic              s_req_vld,
    input  logic [3:0]        s_req_reg,
    input  logic [15:0]       s_req_ptr,
    input  logic              s_req_byte,
    input  logic              s_req_dec,
    output logic              s_rsp_vld,
    output logic [15:0]       s_rsp_ptr
);

    // primary space: byte and word circular buffers
    circbuf_lane #(.BYTE_OK(1'b1)) u_prim (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (p_cfg_wr),
        .cfg_en    (p_cfg_en),
        .cfg_sel   (p_cfg_sel),
        .cfg_start (p_cfg_start),
        .cfg_end   (p_cfg_end),
        .req_vld   (p_req_vld),
        .req_reg   (p_req_reg),
        .req_ptr   (p_req_ptr),
        .req_byte  (p_req_byte),
        .req_dec   (p_req_dec),
        .rsp_vld   (p_rsp_vld),
        .rsp_ptr   (p_rsp_ptr)
    );

    // secondary space: word circular buffers only
    circbuf_lane #(.BYTE_OK(1'b0)) u_sec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (s_cfg_wr),
        .cfg_en    (s_cfg_en),
        .cfg_sel   (s_cfg_sel),
        .cfg_start (s_cfg_start),
        .cfg_end   (s_cfg_end),
        .req_vld   (s_req_vld),
        .req_reg   (s_req_reg),
        .req_ptr   (s_req_ptr),
        .req_byte  (s_req_byte),
        .req_dec   (s_req_dec),
        .rsp_vld   (s_rsp_vld),
        .rsp_ptr   (s_rsp_ptr)
    );

endmodule

// File: tb/circbuf_agen_tb.sv
module circbuf_agen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        p_cfg_wr = 0, p_cfg_en = 0, p_req_vld = 0, p_req_byte = 0, p_req_dec = 0;
    logic [3:0]  p_cfg_sel = 0, p_req_reg = 0;
    logic [15:0] p_cfg_start = 0, p_cfg_end = 0, p_req_ptr = 0;
    logic        s_cfg_wr = 0, s_cfg_en = 0, s_req_vld = 0, s_req_byte = 0, s_req_dec = 0;
    logic [3:0]  s_cfg_sel = 0, s_req_reg = 0;
    logic [15:0] s_cfg_start = 0, s_cfg_end = 0, s_req_ptr = 0;
    logic        p_rsp_vld, s_rsp_vld;
    logic [15:0] p_rsp_ptr, s_rsp_ptr;

    int checks = 0;
    int errors = 0;

    // bench copy of each space's configuration
    logic        m_en [2];
    logic [3:0]  m_sel[2];
    logic [15:0] m_st [2];
    logic [15:0] m_nd [2];

    circbuf_agen dut_i (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected next pointer from the requirements
    function automatic logic [15:0] model(input int sp, input logic [3:0] rg, input logic [15:0] p,
                                          input logic b, input logic d);
        int unsigned step = b ? 1 : 2;
        int unsigned w    = p >> 1;
        bit          on;
        on = m_en[sp] && (m_sel[sp] != 4'd15) && (rg == m_sel[sp]) && (sp == 0 || !b);
        if (on && !d && w == (m_nd[sp] >> 1) && (!b || p[0]))
            return m_st[sp] & 16'hFFFE;
        if (on && d && w == (m_st[sp] >> 1) && (!b || !p[0]))
            return (m_nd[sp] & 16'hFFFE) | 16'(b);
        return d ? p - 16'(step) : p + 16'(step);
    endfunction

    task automatic config_space(input int sp, input logic en, input logic [3:0] sel,
                                input logic [15:0] st, input logic [15:0] nd);
        @(negedge clk);
        if (sp == 0) begin
            p_cfg_wr = 1; p_cfg_en = en; p_cfg_sel = sel; p_cfg_start = st; p_cfg_end = nd;
        end else begin
            s_cfg_wr = 1; s_cfg_en = en; s_cfg_sel = sel; s_cfg_start = st; s_cfg_end = nd;
        end
        @(negedge clk);
        p_cfg_wr = 0; s_cfg_wr = 0;
        m_en[sp] = en; m_sel[sp] = sel; m_st[sp] = st; m_nd[sp] = nd;
    endtask

    task automatic req(input int sp, input logic [3:0] rg, input logic [15:0] p,
                       input logic b, input logic d, input string tag);
        logic [15:0] exp = model(sp, rg, p, b, d);
        @(negedge clk);
        if (sp == 0) begin
            p_req_vld = 1; p_req_reg = rg; p_req_ptr = p; p_req_byte = b; p_req_dec = d;
        end else begin
            s_req_vld = 1; s_req_reg = rg; s_req_ptr = p; s_req_byte = b; s_req_dec = d;
        end
        @(negedge clk);
        p_req_vld = 0; s_req_vld = 0;
        if (sp == 0) begin
            chk(p_rsp_vld == 1'b1, "R2 primary valid", 16'(p_rsp_vld), 16'd1);
            chk(p_rsp_ptr == exp, tag, p_rsp_ptr, exp);
        end else begin
            chk(s_rsp_vld == 1'b1, "R2 secondary valid", 16'(s_rsp_vld), 16'd1);
            chk(s_rsp_ptr == exp, tag, s_rsp_ptr, exp);
        end
    endtask

    initial begin : watchdog
        repeat (WATCHDOG) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        logic [15:0] held;
        for (int i = 0; i < 2; i++) begin
            m_en[i] = 0; m_sel[i] = 4'd15; m_st[i] = 0; m_nd[i] = 0;
        end
        repeat (3) @(negedge clk);
        chk(p_rsp_vld == 0 && s_rsp_vld == 0, "R1 valids in reset", {14'd0, p_rsp_vld, s_rsp_vld}, 16'd0);
        rst_n = 1;
        @(negedge clk);
        chk(p_rsp_vld == 0 && s_rsp_vld == 0, "R1 valids after reset", {14'd0, p_rsp_vld, s_rsp_vld}, 16'd0);

        // R1: unconfigured spaces step linearly even at address 0 edge cases
        req(0, 4'd15, 16'h0000, 0, 0, "R1 unconfigured primary linear");
        req(0, 4'd0,  16'h0000, 0, 1, "R1 unconfigured primary dec");
        req(1, 4'd0,  16'h0000, 0, 1, "R1 unconfigured secondary dec");

        // R2: output holds while idle
        held = p_rsp_ptr;
        repeat (3) @(negedge clk);
        chk(p_rsp_vld == 0, "R2 valid drops when idle", 16'(p_rsp_vld), 16'd0);
        chk(p_rsp_ptr == held, "R2 pointer held when idle", p_rsp_ptr, held);

        // primary: eight-word buffer, register 3; sweep R3 R4 R5 R6 R7 R11
        config_space(0, 1, 4'd3, 16'h0100, 16'h010E);
        for (int a = 16'h00F8; a < 16'h0118; a++) begin
            for (int d = 0; d < 2; d++) begin
                req(0, 4'd3, 16'(a), 1, d[0], "R6 R7 R11 primary byte selected");
                req(0, 4'd5, 16'(a), 1, d[0], "R3 primary byte unselected");
                if (a % 2 == 0) begin
                    req(0, 4'd3, 16'(a), 0, d[0], "R4 R5 R11 primary word selected");
                    req(0, 4'd5, 16'(a), 0, d[0], "R3 primary word unselected");
                end
            end
        end
        // directed edges
        req(0, 4'd3, 16'h010F, 1, 0, "R6 byte inc odd end -> start");
        req(0, 4'd3, 16'h010E, 1, 0, "R6 byte inc even end -> +1");
        req(0, 4'd3, 16'h0100, 1, 1, "R7 byte dec even start -> end|1");
        req(0, 4'd3, 16'h0101, 1, 1, "R7 byte dec odd start -> -1");
        req(0, 4'd3, 16'h010E, 0, 0, "R4 word inc end -> start");
        req(0, 4'd3, 16'h0100, 0, 1, "R5 word dec start -> end");

        // R12: odd configured edges give same results
        config_space(0, 1, 4'd3, 16'h0101, 16'h010F);
        req(0, 4'd3, 16'h010E, 0, 0, "R12 odd cfg word inc wrap");
        req(0, 4'd3, 16'h0100, 1, 1, "R12 odd cfg byte dec wrap");
        req(0, 4'd3, 16'h0100, 0, 1, "R12 odd cfg word dec wrap");

        // R8: register 15 selected
        config_space(0, 1, 4'd15, 16'h0100, 16'h010E);
        req(0, 4'd15, 16'h010E, 0, 0, "R8 reg15 word inc at end linear");
        req(0, 4'd15, 16'h0100, 1, 1, "R8 reg15 byte dec at start linear");

        // R3: disabled space
        config_space(0, 0, 4'd3, 16'h0100, 16'h010E);
        req(0, 4'd3, 16'h010E, 0, 0, "R3 disabled word inc linear");
        req(0, 4'd3, 16'h0100, 0, 1, "R3 disabled word dec linear");

        // secondary: four-word buffer, register 7; sweep R9 and word wraps
        config_space(1, 1, 4'd7, 16'h0200, 16'h0206);
        for (int a = 16'h01FA; a < 16'h020C; a++) begin
            for (int d = 0; d < 2; d++) begin
                req(1, 4'd7, 16'(a), 1, d[0], "R9 secondary byte never wraps");
                if (a % 2 == 0)
                    req(1, 4'd7, 16'(a), 0, d[0], "R4 R5 secondary word");
            end
        end
        req(1, 4'd7, 16'h0207, 1, 0, "R9 secondary byte inc at odd end");
        req(1, 4'd7, 16'h0200, 1, 1, "R9 secondary byte dec at even start");

        // R10: both spaces in the same cycle with different buffers
        config_space(0, 1, 4'd2, 16'h0040, 16'h0046);
        config_space(1, 1, 4'd2, 16'h0080, 16'h0088);
        @(negedge clk);
        p_req_vld = 1; p_req_reg = 4'd2; p_req_ptr = 16'h0046; p_req_byte = 0; p_req_dec = 0;
        s_req_vld = 1; s_req_reg = 4'd2; s_req_ptr = 16'h0046; s_req_byte = 0; s_req_dec = 0;
        @(negedge clk);
        p_req_vld = 0; s_req_vld = 0;
        chk(p_rsp_ptr == 16'h0040, "R10 primary wraps on own buffer", p_rsp_ptr, 16'h0040);
        chk(s_rsp_ptr == 16'h0048, "R10 secondary linear on own buffer", s_rsp_ptr, 16'h0048);
        @(negedge clk);
        p_req_vld = 1; p_req_ptr = 16'h0080; p_req_dec = 1;
        s_req_vld = 1; s_req_ptr = 16'h0080; s_req_dec = 1;
        @(negedge clk);
        p_req_vld = 0; s_req_vld = 0;
        chk(p_rsp_ptr == 16'h007E, "R10 primary linear at other start", p_rsp_ptr, 16'h007E);
        chk(s_rsp_ptr == 16'h0088, "R10 secondary wraps at own start", s_rsp_ptr, 16'h0088);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule